// File: doc/BRIEF.md
# Dual-Tone Band Period Classifier

This block identifies which pair of telephony signalling tones is present on a line. It receives two one-bit squared waveforms, one from the low-band path and one from the high-band path. Each is the output of a zero-crossing comparator that sits further up the chain. The block times the interval between rising edges of each waveform in cycles of its system clock, nominally 3.579545 MHz. It then matches each interval against fixed acceptance windows for four nominal tones per band.

Each band reports a tone-present flag and a 2-bit tone index. A pair-valid flag rises once both bands have produced the same index on four consecutive periods. An inhibit input removes the highest high-band tone from the set of tones the block recognises. A synchronous power-down input clears the block and holds it cleared. All window limits are integer cycle counts that are worked out at elaboration from the clock frequency parameter.

Top module: `dtmf_tone_classifier`

## Requirements
- R1: A low-band period whose frequency lies within ±1.5% of 697, 770, 852 or 941 Hz sets the low tone flag to 1 with index 0, 1, 2 or 3 respectively.
- R2: A high-band period whose frequency lies within ±1.5% of 1209, 1336, 1477 or 1633 Hz sets the high tone flag to 1 with index 0, 1, 2 or 3 respectively.
- R3: A period whose frequency lies outside every ±1.5% window drops that band's tone flag to 0. This includes the band from 1.5% to 3.5% deviation and anything beyond it.
- R4: A band's flag and index follow its most recently completed period. The index reads 0 whenever the flag is 0.
- R5: If a band's input has no rising edge for CLK_HZ/650 cycles (low band) or CLK_HZ/1150 cycles (high band), that band's tone flag drops to 0.
- R6: While the inhibit input is high, a high-band period that matches 1633 Hz (index 3) is reported as no tone. The other high-band tones are unaffected.
- R7: Pair-valid is 1 only while both bands have classified four consecutive periods, each band to one unchanging index. It falls on the first period that classifies to another index, to no tone, or that times out.
- R8: While power-down is high, every flag and index is 0 from the next clock edge onward, whatever the inputs do.
- R9: After asynchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (counting time base) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Synchronous power-down, active high |
| inh_i | input | 1 | Inhibit the 1633 Hz high-band tone |
| low_sq_i | input | 1 | Squared low-band signal |
| high_sq_i | input | 1 | Squared high-band signal |
| low_tone_o | output | 1 | Low-band tone present |
| low_idx_o | output | 2 | Low-band tone index |
| high_tone_o | output | 1 | High-band tone present |
| high_idx_o | output | 2 | High-band tone index |
| pair_valid_o | output | 1 | Both bands steady for four periods |

## Verification
For every tone, the bench drives periods just outside, exactly on and just inside both edges of the acceptance window, plus one period at 2.5% deviation. An off-by-one in a bound, or a reversed rounding, would accept or reject the wrong edge period. The pair-valid edge is timed against the fifth rising edge: a design that counts the arming edge, or that needs a fifth period, would raise the flag one period early or one period late. The bench also covers a tone change, input dropout, inhibit and power-down while tones keep running. These expose a flag that holds a stale index, never times out, blocks the wrong high-band tone, or resumes during power-down.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;
  typedef logic [1:0] tone_idx_t;

  function automatic int unsigned tone_hz(bit high, int unsigned i);
    case ({high, i[1:0]})
      3'b000:  return 697;
      3'b001:  return 770;
      3'b010:  return 852;
      3'b011:  return 941;
      3'b100:  return 1209;
      3'b101:  return 1336;
      3'b110:  return 1477;
      default: return 1633;
    endcase
  endfunction

  // shortest period accepted: frequency at +1.5%
  function automatic int unsigned per_min(int unsigned clk_hz, int unsigned f_hz);
    longint unsigned num, den;
    num = longint'(clk_hz) * 1000;
    den = longint'(f_hz) * 1015;
    return int'((num + den - 1) / den);
  endfunction

  // longest period accepted: frequency at -1.5%
  function automatic int unsigned per_max(int unsigned clk_hz, int unsigned f_hz);
    longint unsigned num, den;
    num = longint'(clk_hz) * 1000;
    den = longint'(f_hz) * 985;
    return int'(num / den);
  endfunction
endpackage

// File: rtl/period_meter.sv
module period_meter #(
  parameter int unsigned PER_W = 13,
  parameter int unsigned SAT   = 5507
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             sq_i,
  output logic             meas_o,
  output logic             tmo_o,
  output logic [PER_W-1:0] per_o
);
  localparam logic [PER_W-1:0] SAT_C = PER_W'(SAT);

  logic [2:0]       sync_q;
  logic [PER_W-1:0] cnt_q;
  logic             armed_q;
  logic             rise;

  assign rise   = sync_q[1] & ~sync_q[2];
  assign meas_o = rise & armed_q;
  assign tmo_o  = armed_q & ~rise & (cnt_q == SAT_C);
  assign per_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (pd_i) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], sq_i};
      if (rise) begin
        cnt_q   <= PER_W'(1);
        armed_q <= 1'b1;
      end else if (tmo_o) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (armed_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !pd_i) |=> (per_o == PER_W'(1) && armed_q));
  p_sat_disarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_o && !pd_i) |=> !armed_q);
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SAT_C);
endmodule

// File: rtl/band_matcher.sv
module band_matcher
  import dtmf_cls_pkg::*;
#(
  parameter int unsigned CLK_HZ = 3579545,
  parameter bit          HIGH   = 1'b0,
  parameter int unsigned PER_W  = 13
) (
  input  logic [PER_W-1:0] per_i,
  output logic             hit_o,
  output tone_idx_t        idx_o
);
  logic [3:0] win;

  for (genvar g = 0; g < 4; g++) begin : g_win
    localparam logic [PER_W-1:0] LO = PER_W'(per_min(CLK_HZ, tone_hz(HIGH, g)));
    localparam logic [PER_W-1:0] HI = PER_W'(per_max(CLK_HZ, tone_hz(HIGH, g)));
    assign win[g] = (per_i >= LO) && (per_i <= HI);
  end

  assign hit_o = |win;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < 4; i++)
      if (win[i]) idx_o = tone_idx_t'(i);
  end

  always_comb begin
    a_win_disjoint_r1: assert ($onehot0(win));
  end
endmodule

// File: rtl/band_tracker.sv
module band_tracker
  import dtmf_cls_pkg::*;
#(
  parameter int unsigned RUN_N    = 4,
  parameter bit          MASK_TOP = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pd_i,
  input  logic      inh_i,
  input  logic      meas_i,
  input  logic      tmo_i,
  input  logic      hit_i,
  input  tone_idx_t idx_i,
  output logic      tone_o,
  output tone_idx_t idx_o,
  output logic      steady_o
);
  localparam int unsigned     RUN_W = $clog2(RUN_N + 1);
  localparam logic [RUN_W-1:0] RUN_C = RUN_W'(RUN_N);

  logic             tone_q;
  tone_idx_t        idx_q;
  logic [RUN_W-1:0] run_q;
  logic             hit_eff;

  assign hit_eff  = hit_i & ~(MASK_TOP & inh_i & (idx_i == 2'd3));
  assign tone_o   = tone_q;
  assign idx_o    = idx_q;
  assign steady_o = (run_q == RUN_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tone_q <= 1'b0;
      idx_q  <= '0;
      run_q  <= '0;
    end else if (pd_i || tmo_i || (meas_i && !hit_eff)) begin
      tone_q <= 1'b0;
      idx_q  <= '0;
      run_q  <= '0;
    end else if (meas_i) begin
      tone_q <= 1'b1;
      idx_q  <= idx_i;
      if (tone_q && idx_q == idx_i) begin
        if (run_q != RUN_C) run_q <= run_q + 1'b1;
      end else begin
        run_q <= RUN_W'(1);
      end
    end
  end

  p_idx_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tone_o |-> (idx_o == 2'd0));
  p_inh_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MASK_TOP && meas_i && inh_i && idx_i == 2'd3) |=> !tone_o);
  p_switch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_i && !pd_i && tone_o && hit_eff && idx_i != idx_o) |=> !steady_o);
endmodule

// File: rtl/dtmf_tone_classifier.sv
module dtmf_tone_classifier
  import dtmf_cls_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 3579545,
  parameter int unsigned LOW_FLOOR_HZ  = 650,
  parameter int unsigned HIGH_FLOOR_HZ = 1150,
  parameter int unsigned RUN_N         = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_i,
  input  logic       inh_i,
  input  logic       low_sq_i,
  input  logic       high_sq_i,
  output logic       low_tone_o,
  output logic [1:0] low_idx_o,
  output logic       high_tone_o,
  output logic [1:0] high_idx_o,
  output logic       pair_valid_o
);
  localparam int unsigned PER_W = $clog2(CLK_HZ / LOW_FLOOR_HZ + 1);

  logic [1:0] sq, tone, steady;
  tone_idx_t  idx [2];

  assign sq = {high_sq_i, low_sq_i};

  for (genvar b = 0; b < 2; b++) begin : g_band
    localparam int unsigned SAT = (b == 0) ? CLK_HZ / LOW_FLOOR_HZ : CLK_HZ / HIGH_FLOOR_HZ;
    logic             meas, tmo, hit;
    logic [PER_W-1:0] per;
    tone_idx_t        cls;

    period_meter #(.PER_W(PER_W), .SAT(SAT)) u_meter (
      .clk_i, .rst_ni, .pd_i, .sq_i(sq[b]),
      .meas_o(meas), .tmo_o(tmo), .per_o(per)
    );

    band_matcher #(.CLK_HZ(CLK_HZ), .HIGH(b == 1), .PER_W(PER_W)) u_match (
      .per_i(per), .hit_o(hit), .idx_o(cls)
    );

    band_tracker #(.RUN_N(RUN_N), .MASK_TOP(b == 1)) u_track (
      .clk_i, .rst_ni, .pd_i, .inh_i,
      .meas_i(meas), .tmo_i(tmo), .hit_i(hit), .idx_i(cls),
      .tone_o(tone[b]), .idx_o(idx[b]), .steady_o(steady[b])
    );
  end

  assign low_tone_o   = tone[0];
  assign low_idx_o    = idx[0];
  assign high_tone_o  = tone[1];
  assign high_idx_o   = idx[1];
  assign pair_valid_o = &steady;

  p_pair_tones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> (low_tone_o && high_tone_o));
  p_pd_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (!low_tone_o && !high_tone_o && !pair_valid_o));
endmodule

// File: tb/sim_dtmf_tone_classifier.sv
module sim_dtmf_tone_classifier;
  localparam int unsigned CLK_HZ = 357955;
  localparam int LSAT = CLK_HZ / 650;
  localparam int HSAT = CLK_HZ / 1150;

  logic clk = 1'b0, rst_ni = 1'b0, pd = 1'b0, inh = 1'b0;
  logic lo_sq = 1'b0, hi_sq = 1'b0;
  logic lo_tone, hi_tone, valid;
  logic [1:0] lo_idx, hi_idx;
  int lo_per = 0, hi_per = 0;
  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int lf [4] = '{697, 770, 852, 941};
  int hf [4] = '{1209, 1336, 1477, 1633};

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  dtmf_tone_classifier #(.CLK_HZ(CLK_HZ)) u0 (
    .clk_i(clk), .rst_ni, .pd_i(pd), .inh_i(inh),
    .low_sq_i(lo_sq), .high_sq_i(hi_sq),
    .low_tone_o(lo_tone), .low_idx_o(lo_idx),
    .high_tone_o(hi_tone), .high_idx_o(hi_idx),
    .pair_valid_o(valid)
  );

  initial forever begin
    int p;
    p = lo_per;
    if (p == 0) begin lo_sq = 1'b0; @(negedge clk); end
    else begin
      lo_sq = 1'b1; repeat (p / 2) @(negedge clk);
      lo_sq = 1'b0; repeat (p - p / 2) @(negedge clk);
    end
  end

  initial forever begin
    int p;
    p = hi_per;
    if (p == 0) begin hi_sq = 1'b0; @(negedge clk); end
    else begin
      hi_sq = 1'b1; repeat (p / 2) @(negedge clk);
      hi_sq = 1'b0; repeat (p - p / 2) @(negedge clk);
    end
  end

  function automatic int expect_idx(int p, bit high, bit inhibit);
    longint num;
    num = longint'(CLK_HZ) * 1000;
    for (int i = 0; i < 4; i++) begin
      longint f;
      f = high ? hf[i] : lf[i];
      if (num <= longint'(p) * f * 1015 && longint'(p) * f * 985 <= num)
        return (high && inhibit && i == 3) ? -1 : i;
    end
    return -1;
  endfunction

  function automatic int variant(int f, int v);
    case (v)
      0: return int'($ceil(real'(CLK_HZ) * 1000.0 / (f * 1015.0))) - 1;
      1: return int'($ceil(real'(CLK_HZ) * 1000.0 / (f * 1015.0)));
      2: return int'(real'(CLK_HZ) / f);
      3: return int'($floor(real'(CLK_HZ) * 1000.0 / (f * 985.0)));
      4: return int'($floor(real'(CLK_HZ) * 1000.0 / (f * 985.0))) + 1;
      default: return int'(real'(CLK_HZ) / (f * 1.025));
    endcase
  endfunction

  task automatic check_bit(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_band(string req, logic tone, logic [1:0] idx, int exp);
    logic       et;
    logic [1:0] ei;
    et = (exp >= 0);
    ei = (exp >= 0) ? 2'(exp) : 2'd0;
    n_chk++;
    if (tone !== et || idx !== ei) begin
      n_bad++;
      $display("FAIL %s: got tone=%0b idx=%0d expected tone=%0b idx=%0d (cycle %0d)",
               req, tone, idx, et, ei, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung run expected completion");
    finish_run();
  end

  initial begin
    int t0, p, q;
    repeat (5) @(negedge clk);
    // R9: reset state
    check_band("R9 low", lo_tone, lo_idx, -1);
    check_band("R9 high", hi_tone, hi_idx, -1);
    check_bit("R9 valid", valid, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R3 R4: window edges, nominal and 2.5% zone for every tone
    for (int i = 0; i < 4; i++) begin
      for (int v = 0; v < 6; v++) begin
        int lp, hp, el, eh;
        lp = variant(lf[i], v);
        hp = variant(hf[i], v);
        lo_per = lp; hi_per = hp;
        repeat (3 * LSAT + 10) @(negedge clk);
        el = expect_idx(lp, 1'b0, 1'b0);
        eh = expect_idx(hp, 1'b1, 1'b0);
        check_band(el < 0 ? "R3 low reject" : "R1 low accept", lo_tone, lo_idx, el);
        check_band(eh < 0 ? "R3 high reject" : "R2 high accept", hi_tone, hi_idx, eh);
      end
    end

    // R3: far too fast in both bands
    lo_per = 100; hi_per = 60;
    repeat (3 * LSAT) @(negedge clk);
    check_band("R3 low fast", lo_tone, lo_idx, -1);
    check_band("R3 high fast", hi_tone, hi_idx, -1);

    // R7: steady pair raises valid, a change drops it on the first new period
    lo_per = variant(lf[1], 2); hi_per = variant(hf[2], 2);
    repeat (8 * LSAT) @(negedge clk);
    check_bit("R7 valid steady", valid, 1'b1);
    check_band("R1 low idx 1", lo_tone, lo_idx, 1);
    check_band("R2 high idx 2", hi_tone, hi_idx, 2);
    p = lo_per; q = variant(lf[3], 2);
    lo_per = q;
    repeat (p + q + 6) @(negedge clk);
    check_bit("R7 valid drop on change", valid, 1'b0);
    check_band("R4 low follows", lo_tone, lo_idx, 3);
    repeat (4 * q + 10) @(negedge clk);
    check_bit("R7 valid back", valid, 1'b1);

    // R5: low input stops
    lo_per = 0;
    repeat (LSAT + 150) @(negedge clk);
    check_band("R5 low timeout", lo_tone, lo_idx, -1);
    check_bit("R7 valid after timeout", valid, 1'b0);
    check_band("R5 high unaffected", hi_tone, hi_idx, 2);

    // R7: valid comes with the fifth rising edge
    p = variant(lf[0], 2);
    lo_per = p; t0 = cyc;
    repeat (4 * p - 4) @(negedge clk);
    check_bit("R7 valid not before fourth period", valid, 1'b0);
    repeat (10) @(negedge clk);
    check_bit("R7 valid at fourth period", valid, 1'b1);

    // R5: high input stops
    hi_per = 0;
    repeat (HSAT + 150) @(negedge clk);
    check_band("R5 high timeout", hi_tone, hi_idx, -1);
    check_bit("R7 valid needs high", valid, 1'b0);

    // R6: inhibit blocks only 1633 Hz
    inh = 1'b1;
    lo_per = variant(lf[3], 2); hi_per = variant(hf[3], 2);
    repeat (8 * LSAT) @(negedge clk);
    check_band("R6 high 1633 inhibited", hi_tone, hi_idx, -1);
    check_band("R6 low unaffected", lo_tone, lo_idx, 3);
    check_bit("R6 no pair", valid, 1'b0);
    hi_per = variant(hf[0], 2);
    repeat (3 * LSAT) @(negedge clk);
    check_band("R6 high 1209 passes", hi_tone, hi_idx, 0);
    inh = 1'b0;
    hi_per = variant(hf[3], 2);
    repeat (8 * LSAT) @(negedge clk);
    check_band("R2 high 1633 released", hi_tone, hi_idx, 3);
    check_bit("R7 pair 941/1633", valid, 1'b1);

    // R8: power-down clears and holds with tones running
    pd = 1'b1;
    repeat (2) @(negedge clk);
    check_band("R8 low cleared", lo_tone, lo_idx, -1);
    check_band("R8 high cleared", hi_tone, hi_idx, -1);
    check_bit("R8 valid cleared", valid, 1'b0);
    repeat (6 * LSAT) @(negedge clk);
    check_band("R8 low held", lo_tone, lo_idx, -1);
    check_band("R8 high held", hi_tone, hi_idx, -1);
    check_bit("R8 valid held", valid, 1'b0);
    pd = 1'b0;
    repeat (8 * LSAT) @(negedge clk);
    check_bit("R8 recovers", valid, 1'b1);

    finish_run();
  end
endmodule